// File: doc/BRIEF.md
# BCD Calendar Clock Read Port

This block gives a processor a small clock peripheral behind two byte-wide registers. It sits on a simple port bus, selected by `bus_sel`. A control register (`bus_sel` = 0) holds the last command byte written. A data register (`bus_sel` = 1) either echoes a stored byte or, in time-read mode, streams the current calendar.

The block keeps its own calendar. Seconds, minutes, hours, day of week, day of month, month and a two-digit year advance on a one-cycle `sec_tick` pulse from a divider elsewhere on the chip. Software writes the time-read command to the control register and then reads the data register seven times. It receives the timestamp as packed BCD bytes from the year down to the seconds. Each byte appears on `bus_rdata` one cycle after the read strobe. The output is registered and holds between reads.

Top module: `rtc_bcd_reader`

## Requirements
- R1: Writing the command code 0x15 (`GET_TIME_CMD`) to the control register (`bus_sel` = 0) returns the read position to the year byte, even in the middle of a sequence.
- R2: While the control register holds 0x15, successive data-register reads (`bus_sel` = 1) return year, month, day of month, day of week, hour, minute, second, in that order.
- R3: The data-register read that follows the seconds byte returns the year byte again, so the sequence repeats every seven reads.
- R4: Each timestamp byte is packed BCD: tens digit in bits 7:4, units digit in bits 3:0, each digit 0 to 9.
- R5: A control-register read returns the stored control byte with bit 7 forced to 1.
- R6: When the control register holds any value other than 0x15, a data-register read returns the last byte written to the data register with bit 7 forced to 1.
- R7: Each `sec_tick` advances the seconds. Seconds and minutes wrap from `SEC_LIMIT`-1 and `MIN_LIMIT`-1 to 0 and carry (defaults 60 and 60). Hours wrap from `HOUR_LIMIT`-1 to 0 (default 24) and carry into the day.
- R8: The day of month runs from 1 to the month's length: 28 for month 2, 30 for months 4, 6, 9 and 11, and 31 otherwise. It then returns to 1 and advances the month. Month 12 returns to 1 and advances the year, which wraps from `YEAR_LIMIT`-1 to 0.
- R9: The day of week runs 0 to 6. It advances by one, wrapping 6 to 0, each time the hours carry into a new day.
- R10: The read position moves only on a data-register read in time-read mode. Idle cycles, ticks, control-register reads and data-register writes leave it unchanged.
- R11: After reset, the control and data registers and `bus_rdata` are 0. The read position is at the year byte. The calendar holds the `INIT_*` parameter values.
- R12: `bus_rdata` changes only in the cycle after a read strobe and holds its value otherwise. A read in the same cycle as a tick returns the value from before the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |

## Verification
The bench builds the block with `SEC_LIMIT` = 3, `MIN_LIMIT` = 2 and `HOUR_LIMIT` = 2, so a full day passes in twelve ticks. It starts the calendar at 31 December of year 99, at the last second of a day, with the weekday at 6. The first tick therefore carries through every field at once: year 99 wraps to 0 and weekday 6 wraps to 0. Over a few thousand further ticks the bench then walks more than a year of month lengths, including the 28-, 30- and 31-day ends. It reads the full timestamp after every simulated day.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int IDX_W      = $clog2(NUM_FIELDS);

  typedef logic [6:0] bin7_t;
  typedef logic [7:0] byte_t;

  typedef enum logic [IDX_W-1:0] {
    FLD_YEAR  = 3'd0,
    FLD_MONTH = 3'd1,
    FLD_MDAY  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_HOUR  = 3'd4,
    FLD_MIN   = 3'd5,
    FLD_SEC   = 3'd6
  } field_e;

  function automatic bin7_t month_length(input bin7_t month);
    case (month)
      7'd2:                        return 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:     return 7'd30;
      default:                     return 7'd31;
    endcase
  endfunction

  function automatic byte_t bin_to_bcd(input bin7_t v);
    byte_t r;
    r[7:4] = 4'(v / 7'd10);
    r[3:0] = 4'(v % 7'd10);
    return r;
  endfunction

endpackage

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
  parameter int W    = 7,
  parameter int LO   = 0,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] value,
  output logic         carry
);

  localparam logic [W-1:0] LO_V   = W'(LO);
  localparam logic [W-1:0] INIT_V = W'(INIT);

  assign carry = inc && (value >= top_val);

  always_ff @(posedge clk) begin
    if (rst)        value <= INIT_V;
    else if (carry) value <= LO_V;
    else if (inc)   value <= value + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && value < top_val) |=> (value == $past(value) + 1'b1)) else $error("counter step"); // R7

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    carry |=> (value == LO_V)) else $error("counter wrap"); // R7

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(value)) else $error("counter moved without increment"); // R7

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24,
  parameter int YEAR_LIMIT = 100,
  parameter int INIT_YEAR  = 0,
  parameter int INIT_MONTH = 1,
  parameter int INIT_MDAY  = 1,
  parameter int INIT_WDAY  = 0,
  parameter int INIT_HOUR  = 0,
  parameter int INIT_MIN   = 0,
  parameter int INIT_SEC   = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  output logic [NUM_FIELDS-1:0][6:0]    cal
);

  localparam bin7_t SEC_TOP  = 7'(SEC_LIMIT - 1);
  localparam bin7_t MIN_TOP  = 7'(MIN_LIMIT - 1);
  localparam bin7_t HOUR_TOP = 7'(HOUR_LIMIT - 1);
  localparam bin7_t YEAR_TOP = 7'(YEAR_LIMIT - 1);

  bin7_t sec_v, min_v, hour_v, mday_v, wday_v, month_v, year_v;
  logic  sec_c, min_c, hour_c, mday_c, wday_c, month_c, year_c;
  bin7_t mday_top;

  assign mday_top = month_length(month_v);

  rtc_wrap_counter #(.W(7), .LO(0), .INIT(INIT_SEC)) u_sec (
    .clk(clk), .rst(rst), .inc(tick), .top_val(SEC_TOP),
    .value(sec_v), .carry(sec_c));

  rtc_wrap_counter #(.W(7), .LO(0), .INIT(INIT_MIN)) u_min (
    .clk(clk), .rst(rst), .inc(sec_c), .top_val(MIN_TOP),
    .value(min_v), .carry(min_c));

  rtc_wrap_counter #(.W(7), .LO(0), .INIT(INIT_HOUR)) u_hour (
    .clk(clk), .rst(rst), .inc(min_c), .top_val(HOUR_TOP),
    .value(hour_v), .carry(hour_c));

  rtc_wrap_counter #(.W(7), .LO(0), .INIT(INIT_WDAY)) u_wday (
    .clk(clk), .rst(rst), .inc(hour_c), .top_val(7'd6),
    .value(wday_v), .carry(wday_c));

  rtc_wrap_counter #(.W(7), .LO(1), .INIT(INIT_MDAY)) u_mday (
    .clk(clk), .rst(rst), .inc(hour_c), .top_val(mday_top),
    .value(mday_v), .carry(mday_c));

  rtc_wrap_counter #(.W(7), .LO(1), .INIT(INIT_MONTH)) u_month (
    .clk(clk), .rst(rst), .inc(mday_c), .top_val(7'd12),
    .value(month_v), .carry(month_c));

  rtc_wrap_counter #(.W(7), .LO(0), .INIT(INIT_YEAR)) u_year (
    .clk(clk), .rst(rst), .inc(month_c), .top_val(YEAR_TOP),
    .value(year_v), .carry(year_c));

  always_comb begin
    cal           = '0;
    cal[FLD_YEAR]  = year_v;
    cal[FLD_MONTH] = month_v;
    cal[FLD_MDAY]  = mday_v;
    cal[FLD_WDAY]  = wday_v;
    cal[FLD_HOUR]  = hour_v;
    cal[FLD_MIN]   = min_v;
    cal[FLD_SEC]   = sec_v;
  end

  AST_MDAY_IN_MONTH: assert property (@(posedge clk) disable iff (rst)
    (mday_v >= 7'd1) && (mday_v <= month_length(month_v))) else $error("day outside month"); // R8

  AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (rst)
    (month_v >= 7'd1) && (month_v <= 7'd12)) else $error("month out of range"); // R8

  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
    wday_v <= 7'd6) else $error("weekday out of range"); // R9

  AST_WDAY_FOLLOWS_DAY: assert property (@(posedge clk) disable iff (rst)
    hour_c |=> (wday_v != $past(wday_v))) else $error("weekday did not advance"); // R9

  AST_YEAR_RANGE: assert property (@(posedge clk) disable iff (rst)
    year_v <= YEAR_TOP) else $error("year out of range"); // R8

endmodule

// File: rtl/rtc_bcd_encoder.sv
module rtc_bcd_encoder
  import rtc_pkg::*;
#(
  parameter int N = NUM_FIELDS
) (
  input  logic [N-1:0][6:0] bin,
  output logic [N-1:0][7:0] bcd
);

  for (genvar g = 0; g < N; g++) begin : g_fld
    assign bcd[g] = bin_to_bcd(bin[g]);
  end

endmodule

// File: rtl/rtc_read_index.sv
module rtc_read_index #(
  parameter int N     = 7,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)  idx <= '0;
    else if (adv)    idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (idx == '0)) else $error("index not cleared"); // R1

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && idx == LAST) |=> (idx == '0)) else $error("index not wrapped"); // R3

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST) else $error("index out of range"); // R3

  AST_IDX_STILL: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> $stable(idx)) else $error("index moved"); // R10

endmodule

// File: rtl/rtc_bcd_reader.sv
module rtc_bcd_reader
  import rtc_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter logic [7:0]  GET_TIME_CMD = 8'h15,
  parameter int          SEC_LIMIT    = 60,
  parameter int          MIN_LIMIT    = 60,
  parameter int          HOUR_LIMIT   = 24,
  parameter int          YEAR_LIMIT   = 100,
  parameter int          INIT_YEAR    = 0,
  parameter int          INIT_MONTH   = 1,
  parameter int          INIT_MDAY    = 1,
  parameter int          INIT_WDAY    = 0,
  parameter int          INIT_HOUR    = 0,
  parameter int          INIT_MIN     = 0,
  parameter int          INIT_SEC     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int                ACK_BIT  = DATA_W - 1;
  localparam logic [DATA_W-1:0] ACK_MASK = DATA_W'(1) << ACK_BIT;

  logic [DATA_W-1:0]             ctrl_q;
  logic [DATA_W-1:0]             data_q;
  logic [NUM_FIELDS-1:0][6:0]    cal_bin;
  logic [NUM_FIELDS-1:0][7:0]    cal_bcd;
  logic [IDX_W-1:0]              rd_idx;
  logic                          time_mode;
  logic                          ctrl_wr, data_wr, ctrl_rd, data_rd;
  logic                          idx_clr, idx_adv;

  assign time_mode = (ctrl_q == DATA_W'(GET_TIME_CMD));
  assign ctrl_wr   = bus_wr && !bus_sel;
  assign data_wr   = bus_wr &&  bus_sel;
  assign ctrl_rd   = bus_rd && !bus_sel;
  assign data_rd   = bus_rd &&  bus_sel;
  assign idx_clr   = ctrl_wr && (bus_wdata == DATA_W'(GET_TIME_CMD));
  assign idx_adv   = data_rd && time_mode;

  rtc_calendar #(
    .SEC_LIMIT(SEC_LIMIT), .MIN_LIMIT(MIN_LIMIT), .HOUR_LIMIT(HOUR_LIMIT),
    .YEAR_LIMIT(YEAR_LIMIT), .INIT_YEAR(INIT_YEAR), .INIT_MONTH(INIT_MONTH),
    .INIT_MDAY(INIT_MDAY), .INIT_WDAY(INIT_WDAY), .INIT_HOUR(INIT_HOUR),
    .INIT_MIN(INIT_MIN), .INIT_SEC(INIT_SEC)
  ) u_cal (
    .clk(clk), .rst(rst), .tick(sec_tick), .cal(cal_bin));

  rtc_bcd_encoder #(.N(NUM_FIELDS)) u_enc (
    .bin(cal_bin), .bcd(cal_bcd));

  rtc_read_index #(.N(NUM_FIELDS), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .clr(idx_clr), .adv(idx_adv), .idx(rd_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata;
      if (data_wr) data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (ctrl_rd) begin
      bus_rdata <= ctrl_q | ACK_MASK;
    end else if (data_rd) begin
      if (time_mode) bus_rdata <= DATA_W'(cal_bcd[rd_idx]);
      else           bus_rdata <= data_q | ACK_MASK;
    end
  end

  AST_CTRL_ACK: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> bus_rdata[ACK_BIT]) else $error("control read lacks ack"); // R5

  AST_PLAIN_ACK: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !time_mode) |=> bus_rdata[ACK_BIT]) else $error("data read lacks ack"); // R6

  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst)
    idx_adv |=> (bus_rdata[7:4] <= 4'd9 && bus_rdata[3:0] <= 4'd9)) else $error("non-BCD digit"); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)) else $error("read data moved without read"); // R12

endmodule

// File: tb/rtc_bcd_reader_test.sv
module rtc_bcd_reader_test;

  localparam int SL = 3;
  localparam int ML = 2;
  localparam int HL = 2;
  localparam int YL = 100;
  localparam int I_YEAR = 99, I_MON = 12, I_DAY = 31, I_WDAY = 6;
  localparam int I_HOUR = 1,  I_MIN = 1,  I_SEC = 2;
  localparam logic [7:0] CMD = 8'h15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  always #4 clk = ~clk;

  rtc_bcd_reader #(
    .SEC_LIMIT(SL), .MIN_LIMIT(ML), .HOUR_LIMIT(HL), .YEAR_LIMIT(YL),
    .INIT_YEAR(I_YEAR), .INIT_MONTH(I_MON), .INIT_MDAY(I_DAY),
    .INIT_WDAY(I_WDAY), .INIT_HOUR(I_HOUR), .INIT_MIN(I_MIN), .INIT_SEC(I_SEC)
  ) uut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_wday, m_idx;
  int m_cmd, m_data, m_rdata;

  function automatic int mdays(input int m);
    if (m == 2) return 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int field(input int i);
    case (i)
      0: return m_year;
      1: return m_mon;
      2: return m_day;
      3: return m_wday;
      4: return m_hour;
      5: return m_min;
      default: return m_sec;
    endcase
  endfunction

  task automatic model_tick();
    m_sec++;
    if (m_sec == SL) begin
      m_sec = 0; m_min++;
      if (m_min == ML) begin
        m_min = 0; m_hour++;
        if (m_hour == HL) begin
          m_hour = 0;
          m_wday = (m_wday + 1) % 7;
          m_day++;
          if (m_day > mdays(m_mon)) begin
            m_day = 1; m_mon++;
            if (m_mon > 12) begin
              m_mon = 1;
              m_year = (m_year + 1) % YL;
            end
          end
        end
      end
    end
  endtask

  // One clock: drive at a falling edge, step the model, compare at the next falling edge.
  task automatic step(input bit tk, input bit rd, input bit wr, input bit sel,
                      input logic [7:0] wd, input string tag);
    sec_tick = tk; bus_rd = rd; bus_wr = wr; bus_sel = sel; bus_wdata = wd;
    if (rd) begin
      if (!sel)             m_rdata = m_cmd | 8'h80;
      else if (m_cmd == CMD) m_rdata = bcd(field(m_idx));
      else                  m_rdata = m_data | 8'h80;
    end
    if (wr && !sel && wd == CMD)       m_idx = 0;
    else if (rd && sel && m_cmd == CMD) m_idx = (m_idx + 1) % 7;
    if (wr) begin
      if (!sel) m_cmd = wd;
      else      m_data = wd;
    end
    if (tk) model_tick();
    @(negedge clk);
    sec_tick = 0; bus_rd = 0; bus_wr = 0;
    vectors++;
    if (int'(bus_rdata) != m_rdata) begin
      errors++;
      $display("FAIL %s: rdata=%02h expected %02h", tag, bus_rdata, m_rdata[7:0]);
    end
  endtask

  task automatic rd_data(input string tag); step(0, 1, 0, 1, 8'h00, tag); endtask
  task automatic rd_ctrl(input string tag); step(0, 1, 0, 0, 8'h00, tag); endtask
  task automatic wr_ctrl(input logic [7:0] v, input string tag); step(0, 0, 1, 0, v, tag); endtask
  task automatic wr_data(input logic [7:0] v, input string tag); step(0, 0, 1, 1, v, tag); endtask
  task automatic idle(input string tag); step(0, 0, 0, 0, 8'h00, tag); endtask
  task automatic tick(input string tag); step(1, 0, 0, 0, 8'h00, tag); endtask

  initial begin
    m_sec = I_SEC; m_min = I_MIN; m_hour = I_HOUR; m_day = I_DAY;
    m_mon = I_MON; m_year = I_YEAR; m_wday = I_WDAY; m_idx = 0;
    m_cmd = 0; m_data = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    vectors++;
    if (bus_rdata != 8'h00) begin
      errors++;
      $display("FAIL R11: rdata=%02h expected 00", bus_rdata);
    end
    rd_ctrl("R5 R11 control after reset");
    wr_ctrl(CMD, "R1 enter time mode");
    rd_ctrl("R5 control ack");
    for (int i = 0; i < 7; i++) rd_data("R2 R4 R11 initial timestamp");
    rd_data("R3 wrap to year");
    rd_data("R2 month after wrap");
    wr_ctrl(CMD, "R1 restart mid sequence");
    rd_data("R1 year after restart");
    rd_ctrl("R10 control read in sequence");
    wr_data(8'h33, "R10 data write in sequence");
    idle("R12 idle hold");
    idle("R12 idle hold");
    rd_data("R10 month still next");
    wr_ctrl(8'h07, "R6 leave time mode");
    rd_data("R6 plain data");
    rd_data("R6 R10 plain data again");
    wr_data(8'h85, "R6 write data");
    rd_data("R6 plain data 85");
    rd_ctrl("R5 control 07");
    wr_ctrl(CMD, "R1 back to time mode");
    step(1, 1, 0, 1, 8'h00, "R12 read with tick sees old year");
    wr_ctrl(CMD, "R1 restart");
    for (int i = 0; i < 7; i++) rd_data("R7 R8 R9 full rollover");
    for (int d = 0; d < 400; d++) begin
      for (int t = 0; t < SL * ML * HL; t++) tick("R7 R12 tick");
      wr_ctrl(CMD, "R1 daily restart");
      for (int i = 0; i < 7; i++) rd_data("R2 R8 R9 daily timestamp");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule